// File: doc/BRIEF.md
# Temperature Alarm Flag Logic

This block keeps the most recent temperature result of a digital thermometer and decides whether that result lies outside a pair of programmable trip points. A start strobe launches a conversion. A counter models how long the conversion takes, and the time depends on the selected resolution. When the counter expires, the block takes the 16-bit two's complement result presented by the sensing side. It clears the low bits that the chosen resolution leaves undefined and stores the word. In the same clock edge it updates an alarm flag.

The alarm compare uses the integer-degree byte of the result, bits 11 down to 4, treated as a signed 8-bit number. That byte is compared against an 8-bit signed upper limit and an 8-bit signed lower limit, and both thresholds are inclusive. The flag is evaluated only when a conversion completes. Moving a limit between conversions therefore leaves the flag alone until the next result arrives.

The timer length for the coarsest resolution is a parameter in clock cycles. Each finer resolution doubles it, which matches the 93.75 / 187.5 / 375 / 750 ms ladder in proportion. Simulation uses a short base length.

Top module: `temp_alarm_top`

## Requirements
- R1: After reset the stored temperature word is 0x0550 (+85 °C), the alarm flag is 0, the busy output is 0 and the done pulse is 0.
- R2: A start strobe sampled while idle raises busy in the next cycle. Busy stays high for exactly BASE_CYCLES << resCode cycles. In the first cycle after busy falls, convDone is high for exactly one cycle, and the new word and flag are visible in that same cycle.
- R3: A start strobe sampled while busy is ignored: the running conversion keeps its length, no extra result is produced, and a resCode change during the conversion affects neither its length nor its masking.
- R4: The resolution code is sampled with the start strobe: 2'b00 = 9 bits (bits 2:0 of the stored word forced to 0), 2'b01 = 10 bits (bits 1:0 forced to 0), 2'b10 = 11 bits (bit 0 forced to 0), 2'b11 = 12 bits (no bit forced).
- R5: Apart from the masked low bits, the stored word equals rawTemp as sampled at completion, including all sign-extension bits (e.g. 0xFE6F at 12 bits is stored as 0xFE6F, -25.0625 °C).
- R6: At completion the alarm flag is set when signed rawTemp[11:4] <= signed loLimit or signed rawTemp[11:4] >= signed hiLimit. Both compares are inclusive, and the limits are sampled at completion.
- R7: Every completed conversion recomputes the flag, so a flag that was set clears at the next conversion whose result lies strictly between the limits.
- R8: Between conversions, changes of hiLimit or loLimit leave alarmFlag and tempWord unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startConv | input | 1 | One-cycle request to begin a conversion |
| resCode | input | 2 | Resolution select, sampled with startConv |
| rawTemp | input | 16 | Two's complement conversion result from the sensing side, sampled at completion |
| hiLimit | input | 8 | Signed upper trip point, inclusive |
| loLimit | input | 8 | Signed lower trip point, inclusive |
| busy | output | 1 | High while a conversion is in progress |
| convDone | output | 1 | One-cycle pulse when a new result has been stored |
| tempWord | output | 16 | Stored temperature with undefined low bits cleared |
| alarmFlag | output | 1 | Alarm condition of the last completed conversion |

## Verification
The assertions assume that startConv is a clean synchronous level and that the sensing side holds rawTemp steady up to the completion edge. They also assume the limits are only meaningful at completion, so stored values may change only together with convDone. The stimulus drives every input on the falling clock edge. It keeps rawTemp constant for the whole conversion. It changes limits only while idle, except in the case that deliberately moves them between conversions. It issues a repeated start, with a different resolution code, only in the middle of a running conversion.

// File: rtl/talarm_pkg.sv
package talarm_pkg;

  localparam int TEMP_W     = 16;
  localparam int LIMIT_W    = 8;
  localparam int FRAC_W     = 4;
  localparam int RES_W      = 2;
  localparam logic [TEMP_W-1:0] RESET_TEMP = 16'h0550;

  typedef enum logic [RES_W-1:0] {
    RES_9B  = 2'b00,
    RES_10B = 2'b01,
    RES_11B = 2'b10,
    RES_12B = 2'b11
  } res_e;

  typedef struct packed {
    logic capture;
    res_e resQ;
  } ctrl_s;

endpackage

// File: rtl/talarm_ctrl.sv
module talarm_ctrl
  import talarm_pkg::*;
#(
  parameter int BASE_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startConv,
  input  logic [RES_W-1:0] resCode,
  output logic             busy,
  output ctrl_s            ctrl
);

  localparam int MAX_CYCLES = BASE_CYCLES << 3;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             busyQ;
  res_e             resQ;
  logic             accept;
  logic             lastCycle;
  logic [CNT_W-1:0] loadVal;

  assign accept    = startConv && !busyQ;
  assign lastCycle = busyQ && (cnt == '0);
  assign loadVal   = (CNT_W'(BASE_CYCLES) << resCode) - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cnt   <= '0;
      resQ  <= RES_12B;
    end else if (accept) begin
      busyQ <= 1'b1;
      cnt   <= loadVal;
      resQ  <= res_e'(resCode);
    end else if (lastCycle) begin
      busyQ <= 1'b0;
    end else if (busyQ) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign busy         = busyQ;
  assign ctrl.capture = lastCycle;
  assign ctrl.resQ    = resQ;

endmodule

// File: rtl/talarm_datapath.sv
module talarm_datapath
  import talarm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_s              ctrl,
  input  logic [TEMP_W-1:0]  rawTemp,
  input  logic [LIMIT_W-1:0] hiLimit,
  input  logic [LIMIT_W-1:0] loLimit,
  output logic [TEMP_W-1:0]  tempWord,
  output logic               alarmFlag,
  output logic               convDone
);

  localparam int OPT_BITS = FRAC_W - 1;

  logic [TEMP_W-1:0]         keepMask;
  logic [TEMP_W-1:0]         maskedTemp;
  logic signed [LIMIT_W-1:0] degField;
  logic                      alarmNext;

  assign keepMask[TEMP_W-1:OPT_BITS] = '1;
  for (genvar i = 0; i < OPT_BITS; i++) begin : g_mask
    assign keepMask[i] = (32'(ctrl.resQ) >= (OPT_BITS - i));
  end

  assign maskedTemp = rawTemp & keepMask;
  assign degField   = maskedTemp[FRAC_W+LIMIT_W-1:FRAC_W];
  assign alarmNext  = (degField <= $signed(loLimit)) || (degField >= $signed(hiLimit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempWord  <= RESET_TEMP;
      alarmFlag <= 1'b0;
      convDone  <= 1'b0;
    end else begin
      convDone <= ctrl.capture;
      if (ctrl.capture) begin
        tempWord  <= maskedTemp;
        alarmFlag <= alarmNext;
      end
    end
  end

endmodule

// File: rtl/temp_alarm_top.sv
module temp_alarm_top
  import talarm_pkg::*;
#(
  parameter int BASE_CYCLES = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startConv,
  input  logic [RES_W-1:0]   resCode,
  input  logic [TEMP_W-1:0]  rawTemp,
  input  logic [LIMIT_W-1:0] hiLimit,
  input  logic [LIMIT_W-1:0] loLimit,
  output logic               busy,
  output logic               convDone,
  output logic [TEMP_W-1:0]  tempWord,
  output logic               alarmFlag
);

  ctrl_s ctrl;

  talarm_ctrl #(.BASE_CYCLES(BASE_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startConv (startConv),
    .resCode   (resCode),
    .busy      (busy),
    .ctrl      (ctrl)
  );

  talarm_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .rawTemp   (rawTemp),
    .hiLimit   (hiLimit),
    .loLimit   (loLimit),
    .tempWord  (tempWord),
    .alarmFlag (alarmFlag),
    .convDone  (convDone)
  );

endmodule

// File: rtl/temp_alarm_checker.sv
module temp_alarm_checker (
  input logic        clk,
  input logic        rstN,
  input logic        startConv,
  input logic        busy,
  input logic        convDone,
  input logic [15:0] tempWord,
  input logic        alarmFlag
);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !convDone); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone); // R2

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> convDone); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startConv) |=> (busy || convDone)); // R3

  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |-> $stable(tempWord)); // R8

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |-> $stable(alarmFlag)); // R8

endmodule

bind temp_alarm_top temp_alarm_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startConv (startConv),
  .busy      (busy),
  .convDone  (convDone),
  .tempWord  (tempWord),
  .alarmFlag (alarmFlag)
);

// File: tb/sim_temp_alarm_top.sv
`timescale 1ns/1ps
module sim_temp_alarm_top;

  localparam int BASE = 4;

  typedef struct {
    logic [15:0] temp;
    logic        alarm;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startConv = 1'b0;
  logic [1:0]  resCode = 2'b11;
  logic [15:0] rawTemp = 16'h0;
  logic [7:0]  hiLimit = 8'h7F;
  logic [7:0]  loLimit = 8'h80;
  logic        busy, convDone, alarmFlag;
  logic [15:0] tempWord;

  int   errors = 0;
  int   checks = 0;
  bit   finished = 0;
  exp_t expQ[$];

  always #5 clk = ~clk;

  temp_alarm_top #(.BASE_CYCLES(BASE)) u0 (
    .clk(clk), .rstN(rstN), .startConv(startConv), .resCode(resCode),
    .rawTemp(rawTemp), .hiLimit(hiLimit), .loLimit(loLimit),
    .busy(busy), .convDone(convDone), .tempWord(tempWord), .alarmFlag(alarmFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: pops one expected item per done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && convDone) begin
        if (expQ.size() == 0) begin
          check("R3 unexpected result", 32'(tempWord), 32'hDEAD);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check({e.tag, " word"}, 32'(tempWord), 32'(e.temp));
          check({e.tag, " alarm"}, 32'(alarmFlag), 32'(e.alarm));
        end
      end
    end
  end

  // driver: computes expectation from the requirements and runs one conversion
  task automatic run_conv(input logic [15:0] raw, input logic [1:0] res,
                          input logic [7:0] hi, input logic [7:0] lo,
                          input bit dupStart, input string tag);
    exp_t e;
    logic [15:0] m;
    logic signed [7:0] deg;
    int n;
    m = 16'hFFFF << (3 - res);            // R4 mask
    e.temp = raw & m;                     // R5
    deg = $signed(e.temp[11:4]);
    e.alarm = (deg <= $signed(lo)) || (deg >= $signed(hi)); // R6
    e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    rawTemp = raw; resCode = res; hiLimit = hi; loLimit = lo;
    startConv = 1'b1;
    @(negedge clk);
    startConv = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      if (dupStart && n == 2) begin
        startConv = 1'b1;
        resCode = ~res;                   // R3: must not affect this conversion
      end else begin
        startConv = 1'b0;
      end
      @(negedge clk);
      if (n > 100) break;
    end
    startConv = 1'b0;
    resCode = res;
    check({tag, " busy length R2"}, 32'(n), 32'(BASE << res));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset word", 32'(tempWord), 32'h0550);
    check("R1 reset alarm", 32'(alarmFlag), 0);
    check("R1 reset busy", 32'(busy), 0);
    check("R1 reset done", 32'(convDone), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    run_conv(16'h0191, 2'b11, 8'h1E, 8'h0A, 0, "R5 12-bit in range");
    run_conv(16'h0191, 2'b00, 8'h1E, 8'h0A, 0, "R4 9-bit mask");
    run_conv(16'hFE6F, 2'b01, 8'h1E, 8'hEC, 0, "R6 negative below lo");
    run_conv(16'h01E0, 2'b10, 8'h1E, 8'h0A, 0, "R6 equal hi");
    run_conv(16'h0191, 2'b11, 8'h1E, 8'h0A, 0, "R7 clears");
    run_conv(16'h00A7, 2'b10, 8'h1E, 8'h0A, 0, "R6 equal lo");

    // R8: move limits so the held value would no longer alarm
    @(negedge clk);
    hiLimit = 8'h7F; loLimit = 8'h80;
    repeat (6) @(negedge clk);
    check("R8 flag held after limit change", 32'(alarmFlag), 1);
    check("R8 word held after limit change", 32'(tempWord), 32'h00A6);

    run_conv(16'h07D0, 2'b11, 8'h7F, 8'h80, 0, "R7 +125 no alarm");
    run_conv(16'hFC90, 2'b01, 8'h7F, 8'hC9, 1, "R3 restart ignored -55");
    run_conv(16'hFE6F, 2'b11, 8'h7F, 8'h80, 0, "R5 sign extension");

    repeat (4) @(negedge clk);
    check("R3 no pending results", 32'(expQ.size()), 0);
    finish_run();
  end

endmodule